// File: doc/BRIEF.md
# Halt-State Exit Controller with Edge-Latched Interrupt Sampling

This block sits beside a processor core's timing unit and owns the halted condition that follows a halt instruction. It keeps a T-state sequencer and an edge-captured interrupt request, together with that request's enable flag. Its mask bit arrives as an input. From these it decides when the core stays halted, when it steps aside for a bus hold, and when it restarts at the first T state of an opcode fetch. It also decides whether that fetch is an interrupt acknowledge.

One system clock drives the block. A phase register splits each T state into a high half and a low half. The interrupt request is inspected only on high halves. State changes happen only at the end of a low half. The core reports two things: a halt strobe when it executes a halt, and a pre-sample flag for the T state that lies two states before one of its own opcode fetches. In return the controller reports the current T-state kind, a bus-float enable, an acknowledge flag for interrupt-entered fetches, and the enable flag itself.

Top module: `halt_exit_ctrl`

## Requirements
- R1: While `rst` is high, `tstate_o` is 0 (reset), and `float_o`, `fetch_ack_o` and `ie_o` are 0. After `rst` falls, one reset T state follows, then one fetch T state (`tstate_o`=1) with `fetch_ack_o`=0, and then run (`tstate_o`=2).
- R2: `clk_hi_o` alternates every clock and is 1 in the first half of each T state. `tstate_o` changes only at the clock edge that ends a low half.
- R3: A one-cycle `halt_i` pulse during run makes the next T state halt (`tstate_o`=3). `float_o` is 1 in every halt T state.
- R4: A rising edge on `irq_i` sets a pending request that persists after `irq_i` falls.
- R5: A pending request is acted on only while `ie_o` is 1 and `irq_mask_i` is 0. Otherwise the controller stays halted, keeps the request pending, and acts on it once both conditions hold at a later sample.
- R6: A qualified request seen at the high-half sample of a halt T state gives exactly one further halt T state. The state after that is a fetch T state with `fetch_ack_o`=1, `ie_o`=0 and `float_o`=0. Run follows.
- R7: Entering an interrupt fetch clears the pending request. A later halt is not left without a new rising edge.
- R8: While `hold_i` is high at the end of a halt T state, the controller moves to hold (`tstate_o`=4) with `float_o`=1. It stays in hold while `hold_i` is high, and returns to halt, never to fetch, once `hold_i` is low at a T-state end.
- R9: Hold takes precedence over a qualified request. The request stays pending and causes a fetch two T states after the return to halt.
- R10: In run, the request is sampled only in a T state flagged by `presample_i`. A qualified sample there makes the T state two later an acknowledged fetch. Without the flag, run continues.
- R11: Reset from any state clears both the pending request and the enable flag.
- R12: `ie_set_i` sets and `ie_clr_i` clears the enable flag on the next edge. When both are high, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, two per T state |
| rst | input | 1 | Synchronous active-high reset |
| halt_i | input | 1 | Core executed a halt (one-cycle strobe) |
| hold_i | input | 1 | Bus hold request (level) |
| irq_i | input | 1 | Rising-edge interrupt request |
| irq_mask_i | input | 1 | Mask bit for the interrupt, 1 blocks it |
| ie_set_i | input | 1 | Set the interrupt-enable flag |
| ie_clr_i | input | 1 | Clear the interrupt-enable flag |
| presample_i | input | 1 | Current run T state is two before an opcode fetch |
| tstate_o | output | 3 | T-state kind: 0 reset, 1 fetch T1, 2 run, 3 halt, 4 hold |
| clk_hi_o | output | 1 | 1 in the high half of a T state |
| float_o | output | 1 | Bus outputs float |
| fetch_ack_o | output | 1 | Current fetch T1 acknowledges the interrupt |
| ie_o | output | 1 | Interrupt-enable flag |

## Verification
The halt exit is tried with a bare edge pulse, with the edge arriving while masked or while disabled and the gate opening later, and with the edge arriving together with a hold request. Together these separate the sample-then-one-more-T-state timing from early or late exits, and show whether the latch really persists. A second halt after an acknowledge checks that the latch was cleared. In run, a pending request with and without the pre-sample flag tells sampling gated by the core's fetch timing apart from free-running sampling. A reset taken with a request pending shows that reset clears the request rather than leaving it latched.

// File: rtl/hx_pkg.sv
package hx_pkg;
  localparam int ST_W = 3;

  typedef enum logic [ST_W-1:0] {
    ST_RESET = 3'd0,
    ST_FETCH = 3'd1,
    ST_RUN   = 3'd2,
    ST_HALT  = 3'd3,
    ST_HOLD  = 3'd4
  } hx_state_e;
endpackage

// File: rtl/hx_phase.sv
// Splits each T state into a high half and a low half of one clock each.
module hx_phase (
  input  logic clk,
  input  logic rst,
  output logic phase_hi_o
);
  always_ff @(posedge clk) begin
    if (rst) phase_hi_o <= 1'b1;
    else     phase_hi_o <= ~phase_hi_o;
  end
endmodule

// File: rtl/hx_irq_latch.sv
// Rising-edge capture of the interrupt request; an edge in the clear cycle wins.
module hx_irq_latch (
  input  logic clk,
  input  logic rst,
  input  logic irq_i,
  input  logic clr_i,
  output logic pend_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    prev_q <= irq_i;
    if (rst) pend_o <= 1'b0;
    else     pend_o <= (pend_o & ~clr_i) | (irq_i & ~prev_q);
  end
endmodule

// File: rtl/hx_seq.sv
// T-state sequencer: halt, hold, exit timing and the enable flag.
module hx_seq
  import hx_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            phase_hi_i,
  input  logic            halt_i,
  input  logic            hold_i,
  input  logic            pend_i,
  input  logic            mask_i,
  input  logic            ie_set_i,
  input  logic            ie_clr_i,
  input  logic            presample_i,
  output hx_state_e       state_o,
  output logic            float_o,
  output logic            ack_o,
  output logic            ie_o,
  output logic            take_o
);
  hx_state_e state_d;
  logic      go_q, go_d;
  logic      armed_q, armed_d;
  logic      halt_req_q;
  logic      sample_en, qual, take;

  assign qual      = pend_i & ie_o & ~mask_i;
  assign sample_en = (state_o == ST_HALT) | ((state_o == ST_RUN) & presample_i);

  always_comb begin
    state_d = state_o;
    go_d    = go_q;
    armed_d = armed_q;
    take    = 1'b0;
    if (phase_hi_i) begin
      if (sample_en && qual) go_d = 1'b1;
    end else begin
      armed_d = go_q;
      go_d    = 1'b0;
      unique case (state_o)
        ST_RESET: state_d = ST_FETCH;
        ST_FETCH: state_d = ST_RUN;
        ST_RUN: begin
          if (armed_q) begin
            state_d = ST_FETCH;
            take    = 1'b1;
          end else if (halt_req_q) begin
            state_d = ST_HALT;
          end
        end
        ST_HALT: begin
          if (hold_i) begin
            state_d = ST_HOLD;
            armed_d = 1'b0;
          end else if (armed_q) begin
            state_d = ST_FETCH;
            take    = 1'b1;
          end
        end
        ST_HOLD: begin
          if (!hold_i) state_d = ST_HALT;
        end
        default: state_d = ST_RESET;
      endcase
      if (take) armed_d = 1'b0;
    end
  end

  assign take_o = take;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_o    <= ST_RESET;
      float_o    <= 1'b0;
      ack_o      <= 1'b0;
      ie_o       <= 1'b0;
      go_q       <= 1'b0;
      armed_q    <= 1'b0;
      halt_req_q <= 1'b0;
    end else begin
      state_o <= state_d;
      go_q    <= go_d;
      armed_q <= armed_d;
      if (!phase_hi_i) begin
        float_o <= (state_d == ST_HALT) || (state_d == ST_HOLD);
        ack_o   <= take;
      end
      if (take || ie_clr_i) ie_o <= 1'b0;
      else if (ie_set_i)    ie_o <= 1'b1;
      if (!phase_hi_i && state_o == ST_RUN && state_d == ST_HALT) halt_req_q <= 1'b0;
      else if (halt_i)                                             halt_req_q <= 1'b1;
    end
  end
endmodule

// File: rtl/halt_exit_ctrl.sv
module halt_exit_ctrl
  import hx_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            halt_i,
  input  logic            hold_i,
  input  logic            irq_i,
  input  logic            irq_mask_i,
  input  logic            ie_set_i,
  input  logic            ie_clr_i,
  input  logic            presample_i,
  output logic [ST_W-1:0] tstate_o,
  output logic            clk_hi_o,
  output logic            float_o,
  output logic            fetch_ack_o,
  output logic            ie_o
);
  logic      phase_hi, pend, take;
  hx_state_e state;

  hx_phase u_phase (
    .clk        (clk),
    .rst        (rst),
    .phase_hi_o (phase_hi)
  );

  hx_irq_latch u_latch (
    .clk    (clk),
    .rst    (rst),
    .irq_i  (irq_i),
    .clr_i  (take),
    .pend_o (pend)
  );

  hx_seq u_seq (
    .clk         (clk),
    .rst         (rst),
    .phase_hi_i  (phase_hi),
    .halt_i      (halt_i),
    .hold_i      (hold_i),
    .pend_i      (pend),
    .mask_i      (irq_mask_i),
    .ie_set_i    (ie_set_i),
    .ie_clr_i    (ie_clr_i),
    .presample_i (presample_i),
    .state_o     (state),
    .float_o     (float_o),
    .ack_o       (fetch_ack_o),
    .ie_o        (ie_o),
    .take_o      (take)
  );

  assign tstate_o = state;
  assign clk_hi_o = phase_hi;
endmodule

// File: rtl/halt_exit_ctrl_chk.sv
module halt_exit_ctrl_chk
  import hx_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            hold_i,
  input logic [ST_W-1:0] tstate_o,
  input logic            clk_hi_o,
  input logic            float_o,
  input logic            fetch_ack_o,
  input logic            ie_o
);
  // R2: no state change at the end of a high half
  p_tstate_stable_r2: assert property (@(posedge clk) disable iff (rst)
    clk_hi_o |=> $stable(tstate_o));

  // R3: bus floats in every halt T state
  p_float_halt_r3: assert property (@(posedge clk) disable iff (rst)
    (tstate_o == 3'd3) |-> float_o);

  // R6: an acknowledged fetch starts with the enable flag clear
  p_ack_clears_ie_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(fetch_ack_o) |-> (tstate_o == 3'd1) && !ie_o);

  // R8: halt is left only for hold or fetch
  p_halt_exits_r8: assert property (@(posedge clk) disable iff (rst)
    (tstate_o == 3'd3) |=> (tstate_o == 3'd3) || (tstate_o == 3'd4) || (tstate_o == 3'd1));

  // R8: hold returns only to halt
  p_hold_return_r8: assert property (@(posedge clk) disable iff (rst)
    (tstate_o == 3'd4) |=> (tstate_o == 3'd4) || (tstate_o == 3'd3));

  // R8: hold floats the bus
  p_float_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (tstate_o == 3'd4) |-> float_o);
endmodule

bind halt_exit_ctrl halt_exit_ctrl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .hold_i      (hold_i),
  .tstate_o    (tstate_o),
  .clk_hi_o    (clk_hi_o),
  .float_o     (float_o),
  .fetch_ack_o (fetch_ack_o),
  .ie_o        (ie_o)
);

// File: tb/halt_exit_ctrl_test.sv
`timescale 1ns/1ps
module halt_exit_ctrl_test;
  localparam int T_RESET = 0, T_FETCH = 1, T_RUN = 2, T_HALT = 3, T_HOLD = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic halt_i = 0, hold_i = 0, irq_i = 0, irq_mask_i = 0;
  logic ie_set_i = 0, ie_clr_i = 0, presample_i = 0;
  logic [2:0] tstate_o;
  logic clk_hi_o, float_o, fetch_ack_o, ie_o;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  halt_exit_ctrl uut (
    .clk(clk), .rst(rst), .halt_i(halt_i), .hold_i(hold_i), .irq_i(irq_i),
    .irq_mask_i(irq_mask_i), .ie_set_i(ie_set_i), .ie_clr_i(ie_clr_i),
    .presample_i(presample_i), .tstate_o(tstate_o), .clk_hi_o(clk_hi_o),
    .float_o(float_o), .fetch_ack_o(fetch_ack_o), .ie_o(ie_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tstep();
    repeat (2) @(negedge clk);
  endtask

  // Ends aligned on the high half of the first run T state.
  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (3) @(negedge clk);
    check("R1 reset tstate", tstate_o, T_RESET);
    check("R1 reset float", float_o, 0);
    check("R1 reset ack", fetch_ack_o, 0);
    check("R1 reset ie", ie_o, 0);
    rst = 0;
    @(negedge clk);
    check("R2 low half", clk_hi_o, 0);
    check("R1 reset T", tstate_o, T_RESET);
    @(negedge clk);
    check("R2 high half", clk_hi_o, 1);
    check("R1 fetch after reset", tstate_o, T_FETCH);
    check("R1 no ack after reset", fetch_ack_o, 0);
    @(negedge clk);
    check("R2 stable in T", tstate_o, T_FETCH);
    @(negedge clk);
    check("R1 run", tstate_o, T_RUN);
  endtask

  task automatic pulse_ie_set();
    ie_set_i = 1; @(negedge clk); ie_set_i = 0; @(negedge clk);
  endtask

  task automatic pulse_irq();
    irq_i = 1; @(negedge clk); irq_i = 0; @(negedge clk);
  endtask

  task automatic enter_halt();
    halt_i = 1; @(negedge clk); halt_i = 0; @(negedge clk);
    check("R3 halt entered", tstate_o, T_HALT);
    check("R3 float in halt", float_o, 1);
  endtask

  task automatic t_halt_irq();
    pulse_ie_set();
    check("R12 ie set", ie_o, 1);
    enter_halt();
    pulse_irq();
    check("R6 first halt after sample T", tstate_o, T_HALT);
    check("R4 latched after fall", float_o, 1);
    tstep();
    check("R6 one extra halt T", tstate_o, T_HALT);
    tstep();
    check("R6 fetch", tstate_o, T_FETCH);
    check("R6 ack", fetch_ack_o, 1);
    check("R6 ie cleared", ie_o, 0);
    check("R6 float off", float_o, 0);
    tstep();
    check("R6 run after fetch", tstate_o, T_RUN);
    check("R6 ack drops", fetch_ack_o, 0);
  endtask

  task automatic t_latch_cleared();
    pulse_ie_set();
    enter_halt();
    for (int i = 0; i < 4; i++) begin
      tstep();
      check("R7 no exit without new edge", tstate_o, T_HALT);
    end
    pulse_irq(); tstep(); tstep();
    check("R7 new edge exits", tstate_o, T_FETCH);
    tstep();
  endtask

  task automatic t_mask();
    pulse_ie_set();
    irq_mask_i = 1;
    enter_halt();
    pulse_irq();
    for (int i = 0; i < 3; i++) begin
      check("R5 masked stays halted", tstate_o, T_HALT);
      tstep();
    end
    irq_mask_i = 0;
    tstep();
    check("R5 unmasked extra halt T", tstate_o, T_HALT);
    tstep();
    check("R5 unmasked exit", tstate_o, T_FETCH);
    check("R5 unmasked ack", fetch_ack_o, 1);
    tstep();
  endtask

  task automatic t_ie_off();
    enter_halt();
    pulse_irq();
    for (int i = 0; i < 3; i++) begin
      check("R5 disabled stays halted", tstate_o, T_HALT);
      tstep();
    end
    ie_set_i = 1; ie_clr_i = 1; @(negedge clk); ie_set_i = 0; ie_clr_i = 0; @(negedge clk);
    check("R12 clear wins", ie_o, 0);
    check("R5 still halted", tstate_o, T_HALT);
    pulse_ie_set();
    check("R5 enabled, extra halt T pending", tstate_o, T_HALT);
    check("R12 ie set in halt", ie_o, 1);
    tstep();
    check("R5 enabled extra halt T", tstate_o, T_HALT);
    tstep();
    check("R5 enabled exit", tstate_o, T_FETCH);
    tstep();
  endtask

  task automatic t_hold();
    enter_halt();
    hold_i = 1;
    tstep();
    check("R8 hold entered", tstate_o, T_HOLD);
    check("R8 float in hold", float_o, 1);
    tstep();
    check("R8 hold kept", tstate_o, T_HOLD);
    hold_i = 0;
    tstep();
    check("R8 back to halt", tstate_o, T_HALT);
    tstep();
    check("R8 stays halt", tstate_o, T_HALT);
    do_reset();
  endtask

  task automatic t_hold_pending();
    pulse_ie_set();
    enter_halt();
    hold_i = 1;
    pulse_irq();
    check("R9 hold first", tstate_o, T_HOLD);
    tstep();
    check("R9 hold kept with request", tstate_o, T_HOLD);
    tstep();
    check("R9 no fetch during hold", tstate_o, T_HOLD);
    hold_i = 0;
    tstep();
    check("R9 return to halt", tstate_o, T_HALT);
    tstep();
    check("R9 extra halt T", tstate_o, T_HALT);
    tstep();
    check("R9 pending exit", tstate_o, T_FETCH);
    check("R9 ack", fetch_ack_o, 1);
    tstep();
  endtask

  task automatic t_run_sample();
    pulse_ie_set();
    pulse_irq();
    for (int i = 0; i < 3; i++) begin
      check("R10 no sample without flag", tstate_o, T_RUN);
      tstep();
    end
    presample_i = 1; @(negedge clk); presample_i = 0; @(negedge clk);
    check("R10 run between", tstate_o, T_RUN);
    tstep();
    check("R10 ack fetch", tstate_o, T_FETCH);
    check("R10 ack", fetch_ack_o, 1);
    tstep();
    check("R10 run again", tstate_o, T_RUN);
  endtask

  task automatic t_reset_clears();
    pulse_ie_set();
    irq_mask_i = 1;
    enter_halt();
    pulse_irq();
    do_reset();
    check("R11 ie cleared", ie_o, 0);
    irq_mask_i = 0;
    pulse_ie_set();
    enter_halt();
    for (int i = 0; i < 3; i++) begin
      tstep();
      check("R11 request cleared", tstate_o, T_HALT);
    end
    do_reset();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    t_halt_irq();
    t_latch_cleared();
    t_mask();
    t_ie_off();
    t_hold();
    t_hold_pending();
    t_run_sample();
    t_reset_clears();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule